// File: doc/BRIEF.md
# Interrupt Distributor State Tracker

This block holds the per-interrupt bookkeeping of a distributor that serves `NUM_IRQ` interrupt lines and `NUM_CPU` CPU interfaces. Each interrupt keeps four CPU bitmasks: enable, pending, active and group. It also keeps a registered copy of the input level of each line and CPU, one trigger-mode bit shared by all CPUs, and an 8-bit priority. Interrupts numbered below `NUM_BANKED` have one priority per CPU. Interrupts at or above that number share one priority across all CPUs.

A command port applies one operation per clock to one interrupt. The operation carries a set mask and a clear mask over the CPUs. A combinational query port takes an interrupt number and a CPU mask. It returns the effective pending, enable, active, group and level status, the trigger mode and a priority. The hardware inputs are sampled every clock. A rising edge latches the pending bit. For a level-triggered line, the sampled level also counts as pending. The `LEGACY` parameter selects an older behaviour in which only the latched bit counts as pending.

Top module: `irq_dist_state`

## Requirements
- R1: A command with field code 0 (enable), 1 (pending), 2 (active) or 3 (group) ORs `cmd_set_i` into that state mask of interrupt `cmd_irq_i`. The bits of other CPUs in that mask do not change, and the state of other interrupts does not change.
- R2: The same command clears the bits given in `cmd_clr_i`. When a bit appears in both the set and the clear mask, set wins. A hardware edge that latches pending in the same cycle as a clear of that bit also wins.
- R3: Each of the query outputs `q_en_o`, `q_act_o`, `q_grp_o` and `q_lvl_o` is 1 when any CPU in `q_cpu_mask_i` has its bit set for interrupt `q_irq_i`.
- R4: Field code 4 writes the trigger bit of an interrupt. A non-zero set mask makes it 1 (edge-triggered). Otherwise a non-zero clear mask makes it 0 (level-triggered). The bit is read on `q_edge_o`.
- R5: For an edge-triggered interrupt, the CPU input bit at index `irq*NUM_CPU+cpu` of `irq_in_i` is checked at each clock. If it is high at a clock where it was low at the previous clock, the pending bit of that CPU is latched. The latched bit is visible on the query port right after that clock.
- R6: When `LEGACY`=0 and the interrupt is level-triggered, `q_pend_o` is the latched pending bit OR the level of the input as sampled at the last clock, taken over the query mask. A software set of pending therefore stays after the line falls.
- R7: When `LEGACY`=1, `q_pend_o` shows only the latched pending bits. A rising input then latches pending whatever the trigger mode.
- R8: Field code 5 writes `cmd_data_i` as the priority. For an interrupt below `NUM_BANKED`, it writes only the CPUs set in `cmd_set_i`. `q_prio_o` returns the priority of the lowest-numbered CPU in the query mask, or of CPU 0 when the mask is empty.
- R9: For an interrupt at or above `NUM_BANKED`, field code 5 writes one priority shared by all CPUs. The CPU masks have no effect on this write.
- R10: Field code 6 loads `cmd_data_i[0]` into `grp0_en_o` and `cmd_data_i[1]` into `grp1_en_o`.
- R11: After reset, every state bit, trigger bit, priority and group-enable bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Apply the command this clock |
| cmd_field_i | input | 3 | Field code: 0 enable, 1 pending, 2 active, 3 group, 4 trigger, 5 priority, 6 group control |
| cmd_irq_i | input | IRQ_W | Target interrupt |
| cmd_set_i | input | NUM_CPU | CPU set mask |
| cmd_clr_i | input | NUM_CPU | CPU clear mask |
| cmd_data_i | input | PRIO_W | Priority or control value |
| irq_in_i | input | NUM_IRQ*NUM_CPU | Hardware lines, index irq*NUM_CPU+cpu |
| q_irq_i | input | IRQ_W | Queried interrupt |
| q_cpu_mask_i | input | NUM_CPU | Queried CPUs |
| q_pend_o | output | 1 | Effective pending status |
| q_en_o | output | 1 | Enable status |
| q_act_o | output | 1 | Active status |
| q_grp_o | output | 1 | Group status |
| q_lvl_o | output | 1 | Sampled level status |
| q_edge_o | output | 1 | Trigger mode, 1 = edge |
| q_prio_o | output | PRIO_W | Priority of the lowest masked CPU |
| grp0_en_o | output | 1 | Group 0 enable |
| grp1_en_o | output | 1 | Group 1 enable |

## Verification
Some rules are checked by assertions on every cycle. These cover set and clear landing in the mask of the addressed interrupt, untouched interrupts keeping their state, edge latches surviving a conflicting clear, and trigger and control writes. They also cover priority banks of unselected CPUs staying stable, and a sampled level on a level-triggered line always showing as pending. Other rules can only be shown by the bench scenarios. These are the difference between a software latch and the live level after the line falls, the legacy instance ignoring the level, lowest-CPU priority selection and reset values. The bench drives a normal and a legacy instance with the same stimulus. A behavioural model is compared with both on every clock.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  typedef enum logic [2:0] {
    FLD_ENABLE = 3'd0,
    FLD_PEND   = 3'd1,
    FLD_ACTIVE = 3'd2,
    FLD_GROUP  = 3'd3,
    FLD_TRIG   = 3'd4,
    FLD_PRIO   = 3'd5,
    FLD_CTRL   = 3'd6
  } field_e;

  localparam int NUM_PLANES = 4;
endpackage

// File: rtl/irqd_bitplane.sv
module irqd_bitplane #(
  parameter int N  = 32,
  parameter int C  = 4,
  parameter int IW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_irq,
  input  logic [C-1:0]   set_m,
  input  logic [C-1:0]   clr_m,
  input  logic [N*C-1:0] hw_set,
  output logic [N*C-1:0] st_o
);
  logic [N*C-1:0] st_q;
  logic [N*C-1:0] st_d;
  logic           upd;

  // next state: clear first, then set, then hardware set (set wins)
  always_comb begin
    st_d = st_q;
    for (int i = 0; i < N; i++) begin
      if (wr_en && (wr_irq == IW'(i))) begin
        st_d[i*C +: C] = (st_q[i*C +: C] & ~clr_m) | set_m;
      end
    end
    st_d = st_d | hw_set;
  end

  assign upd = wr_en | (|hw_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (upd) begin
      st_q <= st_d;
    end
  end

  assign st_o = st_q;

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_set_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_irq == IW'(g)) |=>
        ((st_q[g*C +: C] & $past(set_m)) == $past(set_m)));
    assert_clr_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_irq == IW'(g) && hw_set[g*C +: C] == '0) |=>
        ((st_q[g*C +: C] & $past(clr_m & ~set_m)) == '0));
    assert_other_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && wr_irq == IW'(g)) && hw_set[g*C +: C] == '0) |=>
        $stable(st_q[g*C +: C]));
  end
endmodule

// File: rtl/irqd_line_in.sv
module irqd_line_in #(
  parameter int N      = 32,
  parameter int C      = 4,
  parameter int IW     = 5,
  parameter bit LEGACY = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*C-1:0] irq_in,
  input  logic           trig_wr,
  input  logic [IW-1:0]  trig_irq,
  input  logic [C-1:0]   set_m,
  input  logic [C-1:0]   clr_m,
  output logic [N*C-1:0] lvl_o,
  output logic [N-1:0]   edge_o,
  output logic [N*C-1:0] pend_hw_o
);
  logic [N*C-1:0] lvl_q;
  logic [N-1:0]   trig_q;
  logic [N-1:0]   trig_d;
  logic [N*C-1:0] rise;

  always_comb begin
    trig_d = trig_q;
    for (int i = 0; i < N; i++) begin
      if (trig_wr && (trig_irq == IW'(i))) begin
        if (|set_m) begin
          trig_d[i] = 1'b1;
        end else if (|clr_m) begin
          trig_d[i] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
    end else if (trig_wr) begin
      trig_q <= trig_d;
    end
  end

  // the level register also serves as the previous sample for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else begin
      lvl_q <= irq_in;
    end
  end

  assign rise = irq_in & ~lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_hw
    assign pend_hw_o[g*C +: C] = rise[g*C +: C] & {C{trig_q[g] | LEGACY}};

    assert_trig_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_wr && trig_irq == IW'(g) && (|set_m)) |=> trig_q[g]);
    assert_trig_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_wr && trig_irq == IW'(g) && !(|set_m) && (|clr_m)) |=> !trig_q[g]);
  end

  assign lvl_o  = lvl_q;
  assign edge_o = trig_q;
endmodule

// File: rtl/irqd_prio_store.sv
module irqd_prio_store #(
  parameter int N  = 32,
  parameter int C  = 4,
  parameter int B  = 16,
  parameter int IW = 5,
  parameter int CW = 2,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_irq,
  input  logic [C-1:0]  cpu_m,
  input  logic [PW-1:0] data,
  input  logic [IW-1:0] rd_irq,
  input  logic [CW-1:0] rd_cpu,
  output logic [PW-1:0] rd_prio
);
  localparam int NB  = (B > 0) ? B : 1;
  localparam int NS  = (N > B) ? (N - B) : 1;
  localparam int NSU = (N > B) ? (N - B) : 0;

  logic [PW-1:0] bank_q [NB][C];
  logic [PW-1:0] bank_d [NB][C];
  logic [PW-1:0] shr_q  [NS];
  logic [PW-1:0] shr_d  [NS];

  always_comb begin
    bank_d = bank_q;
    shr_d  = shr_q;
    for (int b = 0; b < B; b++) begin
      for (int c = 0; c < C; c++) begin
        if (wr_en && (wr_irq == IW'(b)) && cpu_m[c]) begin
          bank_d[b][c] = data;
        end
      end
    end
    for (int s = 0; s < NSU; s++) begin
      if (wr_en && (wr_irq == IW'(B + s))) begin
        shr_d[s] = data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) begin
        for (int c = 0; c < C; c++) begin
          bank_q[b][c] <= '0;
        end
      end
      for (int s = 0; s < NS; s++) begin
        shr_q[s] <= '0;
      end
    end else if (wr_en) begin
      bank_q <= bank_d;
      shr_q  <= shr_d;
    end
  end

  always_comb begin
    rd_prio = '0;
    for (int b = 0; b < B; b++) begin
      for (int c = 0; c < C; c++) begin
        if ((rd_irq == IW'(b)) && (rd_cpu == CW'(c))) begin
          rd_prio = bank_q[b][c];
        end
      end
    end
    for (int s = 0; s < NSU; s++) begin
      if (rd_irq == IW'(B + s)) begin
        rd_prio = shr_q[s];
      end
    end
  end

  for (genvar b = 0; b < B; b++) begin : g_bank_chk
    for (genvar c = 0; c < C; c++) begin : g_cpu_chk
      assert_bank_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_irq == IW'(b) && cpu_m[c])) |=> $stable(bank_q[b][c]));
    end
  end

  for (genvar s = 0; s < NSU; s++) begin : g_shr_chk
    assert_shared_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_irq == IW'(B + s)) |=> (shr_q[s] == $past(data)));
  end
endmodule

// File: rtl/irqd_query.sv
module irqd_query #(
  parameter int N      = 32,
  parameter int C      = 4,
  parameter int IW     = 5,
  parameter int CW     = 2,
  parameter bit LEGACY = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*C-1:0] en_st,
  input  logic [N*C-1:0] pend_st,
  input  logic [N*C-1:0] act_st,
  input  logic [N*C-1:0] grp_st,
  input  logic [N*C-1:0] lvl_st,
  input  logic [N-1:0]   edge_st,
  input  logic [IW-1:0]  q_irq,
  input  logic [C-1:0]   q_mask,
  output logic           q_pend,
  output logic           q_en,
  output logic           q_act,
  output logic           q_grp,
  output logic           q_lvl,
  output logic           q_edge,
  output logic [CW-1:0]  q_cpu
);
  logic [C-1:0] en_s, pend_s, act_s, grp_s, lvl_s;
  logic         edge_s;

  always_comb begin
    en_s   = '0;
    pend_s = '0;
    act_s  = '0;
    grp_s  = '0;
    lvl_s  = '0;
    edge_s = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (q_irq == IW'(i)) begin
        en_s   = en_st[i*C +: C];
        pend_s = pend_st[i*C +: C];
        act_s  = act_st[i*C +: C];
        grp_s  = grp_st[i*C +: C];
        lvl_s  = lvl_st[i*C +: C];
        edge_s = edge_st[i];
      end
    end
  end

  always_comb begin
    q_cpu = '0;
    for (int c = C - 1; c >= 0; c--) begin
      if (q_mask[c]) begin
        q_cpu = CW'(c);
      end
    end
  end

  assign q_en   = |(en_s & q_mask);
  assign q_act  = |(act_s & q_mask);
  assign q_grp  = |(grp_s & q_mask);
  assign q_lvl  = |(lvl_s & q_mask);
  assign q_edge = edge_s;

  if (LEGACY) begin : g_pend_legacy
    assign q_pend = |(pend_s & q_mask);
  end else begin : g_pend_live
    assign q_pend = (|(pend_s & q_mask)) | (!edge_s && (|(lvl_s & q_mask)));

    assert_level_pends_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (q_lvl && !q_edge) |-> q_pend);
  end
endmodule

// File: rtl/irq_dist_state.sv
module irq_dist_state
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ    = 32,
  parameter int NUM_CPU    = 4,
  parameter int NUM_BANKED = 16,
  parameter int PRIO_W     = 8,
  parameter bit LEGACY     = 1'b0,
  localparam int IRQ_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid_i,
  input  logic [2:0]                 cmd_field_i,
  input  logic [IRQ_W-1:0]           cmd_irq_i,
  input  logic [NUM_CPU-1:0]         cmd_set_i,
  input  logic [NUM_CPU-1:0]         cmd_clr_i,
  input  logic [PRIO_W-1:0]          cmd_data_i,
  input  logic [NUM_IRQ*NUM_CPU-1:0] irq_in_i,
  input  logic [IRQ_W-1:0]           q_irq_i,
  input  logic [NUM_CPU-1:0]         q_cpu_mask_i,
  output logic                       q_pend_o,
  output logic                       q_en_o,
  output logic                       q_act_o,
  output logic                       q_grp_o,
  output logic                       q_lvl_o,
  output logic                       q_edge_o,
  output logic [PRIO_W-1:0]          q_prio_o,
  output logic                       grp0_en_o,
  output logic                       grp1_en_o
);
  localparam int LINES = NUM_IRQ * NUM_CPU;

  field_e           fld;
  logic [LINES-1:0] plane_st [NUM_PLANES];
  logic [LINES-1:0] plane_hw [NUM_PLANES];
  logic [LINES-1:0] lvl_st;
  logic [NUM_IRQ-1:0] edge_st;
  logic [LINES-1:0] pend_hw;
  logic [CPU_W-1:0] q_cpu;
  logic [1:0]       ctrl_q;
  logic [1:0]       ctrl_d;
  logic             ctrl_wr;

  assign fld = field_e'(cmd_field_i);

  always_comb begin
    for (int p = 0; p < NUM_PLANES; p++) begin
      plane_hw[p] = (p == int'(FLD_PEND)) ? pend_hw : '0;
    end
  end

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    irqd_bitplane #(.N(NUM_IRQ), .C(NUM_CPU), .IW(IRQ_W)) u_plane (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cmd_valid_i && (cmd_field_i == 3'(p))),
      .wr_irq (cmd_irq_i),
      .set_m  (cmd_set_i),
      .clr_m  (cmd_clr_i),
      .hw_set (plane_hw[p]),
      .st_o   (plane_st[p])
    );
  end

  irqd_line_in #(.N(NUM_IRQ), .C(NUM_CPU), .IW(IRQ_W), .LEGACY(LEGACY)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in_i),
    .trig_wr   (cmd_valid_i && (fld == FLD_TRIG)),
    .trig_irq  (cmd_irq_i),
    .set_m     (cmd_set_i),
    .clr_m     (cmd_clr_i),
    .lvl_o     (lvl_st),
    .edge_o    (edge_st),
    .pend_hw_o (pend_hw)
  );

  irqd_prio_store #(
    .N(NUM_IRQ), .C(NUM_CPU), .B(NUM_BANKED), .IW(IRQ_W), .CW(CPU_W), .PW(PRIO_W)
  ) u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cmd_valid_i && (fld == FLD_PRIO)),
    .wr_irq  (cmd_irq_i),
    .cpu_m   (cmd_set_i),
    .data    (cmd_data_i),
    .rd_irq  (q_irq_i),
    .rd_cpu  (q_cpu),
    .rd_prio (q_prio_o)
  );

  irqd_query #(
    .N(NUM_IRQ), .C(NUM_CPU), .IW(IRQ_W), .CW(CPU_W), .LEGACY(LEGACY)
  ) u_query (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_st   (plane_st[int'(FLD_ENABLE)]),
    .pend_st (plane_st[int'(FLD_PEND)]),
    .act_st  (plane_st[int'(FLD_ACTIVE)]),
    .grp_st  (plane_st[int'(FLD_GROUP)]),
    .lvl_st  (lvl_st),
    .edge_st (edge_st),
    .q_irq   (q_irq_i),
    .q_mask  (q_cpu_mask_i),
    .q_pend  (q_pend_o),
    .q_en    (q_en_o),
    .q_act   (q_act_o),
    .q_grp   (q_grp_o),
    .q_lvl   (q_lvl_o),
    .q_edge  (q_edge_o),
    .q_cpu   (q_cpu)
  );

  // group enable control
  assign ctrl_wr = cmd_valid_i && (fld == FLD_CTRL);
  assign ctrl_d  = cmd_data_i[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign grp0_en_o = ctrl_q[0];
  assign grp1_en_o = ctrl_q[1];

  assert_edge_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_hw != '0) |=>
      ((plane_st[int'(FLD_PEND)] & $past(pend_hw)) == $past(pend_hw)));
  assert_ctrl_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ({grp1_en_o, grp0_en_o} == $past(cmd_data_i[1:0])));
endmodule

// File: tb/tb_irq_dist_state.sv
`timescale 1ns/1ps
module tb_irq_dist_state;
  localparam int N = 32;
  localparam int C = 4;
  localparam int B = 16;
  localparam int PW = 8;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_field = '0;
  logic [IW-1:0] cmd_irq = '0;
  logic [C-1:0] cmd_set = '0, cmd_clr = '0;
  logic [PW-1:0] cmd_data = '0;
  logic [N*C-1:0] irq_in = '0;
  logic [IW-1:0] q_irq = '0;
  logic [C-1:0] q_mask = '0;

  logic q_pend, q_en, q_act, q_grp, q_lvl, q_edge, g0, g1;
  logic [PW-1:0] q_prio;
  logic l_pend, l_en, l_act, l_grp, l_lvl, l_edge, l_g0, l_g1;
  logic [PW-1:0] l_prio;

  int vectors = 0;
  int miscompares = 0;
  bit armed = 1'b0;

  always #4 clk = ~clk;

  irq_dist_state #(.NUM_IRQ(N), .NUM_CPU(C), .NUM_BANKED(B), .PRIO_W(PW), .LEGACY(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_field_i(cmd_field),
    .cmd_irq_i(cmd_irq), .cmd_set_i(cmd_set), .cmd_clr_i(cmd_clr), .cmd_data_i(cmd_data),
    .irq_in_i(irq_in), .q_irq_i(q_irq), .q_cpu_mask_i(q_mask),
    .q_pend_o(q_pend), .q_en_o(q_en), .q_act_o(q_act), .q_grp_o(q_grp), .q_lvl_o(q_lvl),
    .q_edge_o(q_edge), .q_prio_o(q_prio), .grp0_en_o(g0), .grp1_en_o(g1));

  irq_dist_state #(.NUM_IRQ(N), .NUM_CPU(C), .NUM_BANKED(B), .PRIO_W(PW), .LEGACY(1'b1)) dut_legacy (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_field_i(cmd_field),
    .cmd_irq_i(cmd_irq), .cmd_set_i(cmd_set), .cmd_clr_i(cmd_clr), .cmd_data_i(cmd_data),
    .irq_in_i(irq_in), .q_irq_i(q_irq), .q_cpu_mask_i(q_mask),
    .q_pend_o(l_pend), .q_en_o(l_en), .q_act_o(l_act), .q_grp_o(l_grp), .q_lvl_o(l_lvl),
    .q_edge_o(l_edge), .q_prio_o(l_prio), .grp0_en_o(l_g0), .grp1_en_o(l_g1));

  // behavioural reference
  logic [C-1:0] m_en [N];
  logic [C-1:0] m_pd [N];
  logic [C-1:0] m_lpd [N];
  logic [C-1:0] m_ac [N];
  logic [C-1:0] m_gr [N];
  logic [C-1:0] m_lv [N];
  logic [C-1:0] m_rise [N];
  bit           m_tr [N];
  int           m_bp [B][C];
  int           m_sp [N-B];
  logic [1:0]   m_ctl;

  always @(posedge clk) begin : model
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_en[i] = '0; m_pd[i] = '0; m_lpd[i] = '0; m_ac[i] = '0;
        m_gr[i] = '0; m_lv[i] = '0; m_tr[i] = 1'b0;
      end
      for (int b = 0; b < B; b++) for (int c = 0; c < C; c++) m_bp[b][c] = 0;
      for (int s = 0; s < N-B; s++) m_sp[s] = 0;
      m_ctl = '0;
    end else begin
      for (int i = 0; i < N; i++) m_rise[i] = irq_in[i*C +: C] & ~m_lv[i];
      if (cmd_valid) begin
        case (cmd_field)
          3'd0: m_en[cmd_irq] = (m_en[cmd_irq] & ~cmd_clr) | cmd_set;
          3'd1: begin
            m_pd[cmd_irq]  = (m_pd[cmd_irq] & ~cmd_clr) | cmd_set;
            m_lpd[cmd_irq] = (m_lpd[cmd_irq] & ~cmd_clr) | cmd_set;
          end
          3'd2: m_ac[cmd_irq] = (m_ac[cmd_irq] & ~cmd_clr) | cmd_set;
          3'd3: m_gr[cmd_irq] = (m_gr[cmd_irq] & ~cmd_clr) | cmd_set;
          3'd5: begin
            if (int'(cmd_irq) < B) begin
              for (int c = 0; c < C; c++) if (cmd_set[c]) m_bp[cmd_irq][c] = int'(cmd_data);
            end else m_sp[int'(cmd_irq) - B] = int'(cmd_data);
          end
          3'd6: m_ctl = cmd_data[1:0];
          default: ;
        endcase
      end
      for (int i = 0; i < N; i++) begin
        if (m_tr[i]) m_pd[i] = m_pd[i] | m_rise[i];
        m_lpd[i] = m_lpd[i] | m_rise[i];
        m_lv[i] = irq_in[i*C +: C];
      end
      if (cmd_valid && cmd_field == 3'd4) begin
        if (|cmd_set) m_tr[cmd_irq] = 1'b1;
        else if (|cmd_clr) m_tr[cmd_irq] = 1'b0;
      end
    end
  end

  function automatic int exp_prio();
    int cpu = 0;
    for (int c = C - 1; c >= 0; c--) if (q_mask[c]) cpu = c;
    if (int'(q_irq) < B) return m_bp[q_irq][cpu];
    return m_sp[int'(q_irq) - B];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s irq=%0d mask=%b actual=%0h expected=%0h", tag, q_irq, q_mask, act, exp);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (rst_n && armed) begin
      chk("R1 enable",    int'(q_en),  int'(|(m_en[q_irq] & q_mask)));
      chk("R2 active",    int'(q_act), int'(|(m_ac[q_irq] & q_mask)));
      chk("R3 group",     int'(q_grp), int'(|(m_gr[q_irq] & q_mask)));
      chk("R3 level",     int'(q_lvl), int'(|(m_lv[q_irq] & q_mask)));
      chk("R4 trigger",   int'(q_edge), int'(m_tr[q_irq]));
      chk("R6 pending",   int'(q_pend), int'((|(m_pd[q_irq] & q_mask)) ||
                                               (!m_tr[q_irq] && (|(m_lv[q_irq] & q_mask)))));
      chk("R7 legacy pending", int'(l_pend), int'(|(m_lpd[q_irq] & q_mask)));
      chk("R8 priority",  int'(q_prio), exp_prio());
      chk("R10 control",  int'({g1, g0}), int'(m_ctl));
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic cmd(input logic [2:0] f, input int irq, input logic [C-1:0] s,
                     input logic [C-1:0] c, input logic [PW-1:0] d);
    cmd_valid = 1'b1; cmd_field = f; cmd_irq = IW'(irq);
    cmd_set = s; cmd_clr = c; cmd_data = d;
    tick();
    cmd_valid = 1'b0; cmd_set = '0; cmd_clr = '0;
  endtask

  task automatic query(input int irq, input logic [C-1:0] m);
    q_irq = IW'(irq); q_mask = m;
    tick();
  endtask

  initial begin : watchdog
    #(200000 * 8);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    tick();
    armed = 1'b1;

    // R11: reset state
    query(0, 4'hF);
    chk("R11 pend", int'(q_pend), 0);
    chk("R11 en", int'(q_en), 0);
    chk("R11 prio", int'(q_prio), 0);
    chk("R11 ctrl", int'({g1, g0}), 0);
    query(20, 4'hF);
    chk("R11 edge", int'(q_edge), 0);

    // R1 / R3: masked set
    cmd(3'd0, 3, 4'b0101, 4'b0000, 8'h00);
    query(3, 4'b0010);
    chk("R1 other cpu", int'(q_en), 0);
    query(3, 4'b0100);
    chk("R1 masked cpu", int'(q_en), 1);
    query(4, 4'hF);
    chk("R1 other irq", int'(q_en), 0);
    cmd(3'd2, 20, 4'b1000, 4'b0000, 8'h00);
    cmd(3'd3, 20, 4'b0001, 4'b0000, 8'h00);
    query(20, 4'b1001);
    chk("R3 any active", int'(q_act), 1);
    chk("R3 any group", int'(q_grp), 1);
    query(20, 4'b0110);
    chk("R3 none active", int'(q_act), 0);

    // R2: set wins over clear, then clear alone
    cmd(3'd1, 5, 4'b0011, 4'b0010, 8'h00);
    query(5, 4'b0010);
    chk("R2 set wins", int'(q_pend), 1);
    cmd(3'd1, 5, 4'b0000, 4'b0001, 8'h00);
    query(5, 4'b0001);
    chk("R2 cleared", int'(q_pend), 0);
    query(5, 4'b0010);
    chk("R2 kept", int'(q_pend), 1);

    // R4 / R5: edge-triggered latch
    cmd(3'd4, 7, 4'b0001, 4'b0000, 8'h00);
    query(7, 4'b0010);
    chk("R4 edge mode", int'(q_edge), 1);
    irq_in[7*C + 1] = 1'b1;
    tick();
    chk("R5 latched", int'(q_pend), 1);
    irq_in[7*C + 1] = 1'b0;
    tick();
    chk("R5 held after fall", int'(q_pend), 1);
    cmd(3'd1, 7, 4'b0000, 4'b0010, 8'h00);
    chk("R5 cleared", int'(q_pend), 0);
    // R2: a rising edge beats a clear in the same cycle
    irq_in[7*C + 1] = 1'b1;
    cmd(3'd1, 7, 4'b0000, 4'b0010, 8'h00);
    chk("R2 edge beats clear", int'(q_pend), 1);
    irq_in[7*C + 1] = 1'b0;
    cmd(3'd4, 7, 4'b0000, 4'b0001, 8'h00);
    chk("R4 level mode", int'(q_edge), 0);

    // R6 / R7: level line
    query(9, 4'b0100);
    irq_in[9*C + 2] = 1'b1;
    tick();
    chk("R6 level pending", int'(q_pend), 1);
    chk("R7 legacy latched", int'(l_pend), 1);
    irq_in[9*C + 2] = 1'b0;
    tick();
    chk("R6 level gone", int'(q_pend), 0);
    chk("R7 legacy holds", int'(l_pend), 1);
    cmd(3'd1, 9, 4'b0000, 4'b0100, 8'h00);
    chk("R7 legacy cleared", int'(l_pend), 0);
    irq_in[9*C + 2] = 1'b1;
    tick();
    tick();
    cmd(3'd1, 9, 4'b0000, 4'b0100, 8'h00);
    chk("R7 legacy ignores level", int'(l_pend), 0);
    chk("R6 level still pends", int'(q_pend), 1);
    cmd(3'd1, 9, 4'b0100, 4'b0000, 8'h00);
    irq_in[9*C + 2] = 1'b0;
    tick();
    chk("R6 software latch survives", int'(q_pend), 1);

    // R8: banked priority
    cmd(3'd5, 2, 4'b0110, 4'b0000, 8'h40);
    query(2, 4'b0100);
    chk("R8 banked cpu2", int'(q_prio), 'h40);
    query(2, 4'b0001);
    chk("R8 banked cpu0", int'(q_prio), 0);
    query(2, 4'b0000);
    chk("R8 empty mask", int'(q_prio), 0);
    query(2, 4'b1010);
    chk("R8 lowest cpu", int'(q_prio), 'h40);

    // R9: shared priority
    cmd(3'd5, 25, 4'b0001, 4'b0000, 8'hA5);
    query(25, 4'b1000);
    chk("R9 shared", int'(q_prio), 'hA5);
    query(26, 4'b1000);
    chk("R9 neighbour", int'(q_prio), 0);
    cmd(3'd5, 25, 4'b0000, 4'b1111, 8'h3C);
    query(25, 4'b0010);
    chk("R9 mask ignored", int'(q_prio), 'h3C);

    // R10: group enables
    cmd(3'd6, 0, 4'b0000, 4'b0000, 8'h02);
    chk("R10 grp0", int'(g0), 0);
    chk("R10 grp1", int'(g1), 1);
    cmd(3'd6, 0, 4'b0000, 4'b0000, 8'h01);
    chk("R10 swap", int'({g1, g0}), 1);

    // mixed random traffic, compared by the model each clock
    for (int k = 0; k < 4000; k++) begin
      cmd_valid = ($urandom_range(3) != 0);
      cmd_field = 3'($urandom_range(6));
      cmd_irq   = IW'($urandom_range(N - 1));
      cmd_set   = C'($urandom);
      cmd_clr   = C'($urandom);
      cmd_data  = PW'($urandom);
      if ($urandom_range(1) == 1) begin
        int bit_i = $urandom_range(N * C - 1);
        irq_in[bit_i] = ~irq_in[bit_i];
      end
      q_irq  = IW'($urandom_range(N - 1));
      q_mask = C'($urandom);
      tick();
    end
    cmd_valid = 1'b0;
    tick();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule